// File: doc/BRIEF.md
# Delta Bit-Plane XOR Transform

This block turns one 1024-bit memory chunk into a form that a later entropy coder can compress well. The chunk is read as thirty-two 32-bit integers, whatever type the data originally held. Word 0 passes straight through as a base value. Each later word is reduced to its signed difference from the word just before it. These 31 differences, 33 bits each, are then turned sideways into 33 bit planes of 31 bits. Each plane is XORed with the plane one bit above it. When neighbouring values lie close together, the high planes come out as zeros, whether the differences are positive or negative.

A chunk enters on a valid/ready handshake and leaves on a second valid/ready handshake. The result is the base word plus all 33 transformed planes on one wide bus, with the highest plane first. The datapath is a two-stage register pipeline. It takes a new chunk on every cycle while the consumer keeps up, and it holds its results steady when the consumer stalls.

Top module: `dbx_transform`

## Requirements
- R1: `out_base` equals bits [31:0] (word 0) of the chunk whose result is being presented.
- R2: For i = 1..31, with word i at `in_chunk[32*i +: 32]` read as a signed integer, delta i equals word i minus word i-1, computed exactly as a 33-bit two's-complement value.
- R3: The difference never overflows, even at the extremes. For example, 0x7FFFFFFF after 0x80000000 gives +0x0FFFFFFFF, and 0x80000000 after 0x7FFFFFFF gives -0x0FFFFFFFF.
- R4: Raw plane k (k = 0..32) is 31 bits wide, and its bit i-1 holds bit k of delta i.
- R5: Transformed plane 32 equals raw plane 32. For k = 0..31, transformed plane k equals raw plane k XOR raw plane k+1, so the chunk can be rebuilt exactly from the base and the planes.
- R6: `out_planes[31*j +: 31]` holds transformed plane 32-j. Slot 0 carries the highest plane and slot 32 carries plane 0.
- R7: A chunk of 32 equal words yields 33 all-zero planes.
- R8: A chunk accepted at one rising edge appears on the output two edges later. With `out_ready` held high, one chunk is accepted and one is delivered every cycle, and `in_ready` is high whenever the output register is empty or being read.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_base` and `out_planes` hold their values.
- R10: After a synchronous reset, `out_valid` is low and `in_ready` is high.
- R11: Chunks leave in the order they were accepted, with none lost or duplicated. At most two chunks are held inside the block, and once two are held under a stalled output, `in_ready` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input chunk present |
| in_ready | output | 1 | Block can take a chunk this cycle |
| in_chunk | input | 1024 | Chunk, word i at bits [32*i +: 32] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_base | output | 32 | Word 0 of the chunk |
| out_planes | output | 1023 | 33 transformed planes, slot j = plane 32-j |

## Verification
The hardest state to reach from the ports is a full pipeline under a stalled consumer. Both stages must hold a valid chunk, `in_ready` must fall, and the held output must stay frozen while a third chunk waits at the input. The bench reaches this state by driving `out_ready` low for eight cycles while it offers chunks back to back. It then releases the stall and confirms that every chunk arrives in order. For the data path, the bench uses a hand-built single-spike chunk to pin the bit and slot positions, and extreme alternating words to exercise the 33-bit difference. On other chunks it applies an inverse reconstruction, which closes the loop on the XOR chain.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  localparam int unsigned DBX_WORD_W    = 32;
  localparam int unsigned DBX_NUM_WORDS = 32;

  // Output slot that carries transformed plane k (highest plane in slot 0).
  function automatic int unsigned dbx_slot(input int unsigned k, input int unsigned nplanes);
    return nplanes - 1 - k;
  endfunction
endpackage

// File: rtl/dbx_stage_reg.sv
module dbx_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Data register with enable only; validity is tracked separately.
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/dbx_delta.sv
module dbx_delta #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 32,
  localparam int unsigned DELTA_W  = WORD_W + 1,
  localparam int unsigned NDELTA   = NUM_WORDS - 1,
  localparam int unsigned CHUNK_W  = WORD_W * NUM_WORDS
) (
  input  logic [CHUNK_W-1:0]        chunk,
  output logic [WORD_W-1:0]         base,
  output logic [NDELTA*DELTA_W-1:0] deltas
);
  assign base = chunk[WORD_W-1:0];

  // Each neighbour pair is sign-extended by one bit, so the difference is exact.
  for (genvar i = 1; i < NUM_WORDS; i++) begin : g_diff
    logic [WORD_W-1:0] cur_w, prv_w;
    assign cur_w = chunk[i*WORD_W +: WORD_W];
    assign prv_w = chunk[(i-1)*WORD_W +: WORD_W];
    assign deltas[(i-1)*DELTA_W +: DELTA_W] =
      {cur_w[WORD_W-1], cur_w} - {prv_w[WORD_W-1], prv_w};
  end
endmodule

// File: rtl/dbx_bitplane.sv
module dbx_bitplane #(
  parameter int unsigned DELTA_W  = 33,
  parameter int unsigned NDELTA   = 31,
  localparam int unsigned NPLANE  = DELTA_W,
  localparam int unsigned PLANE_BUS_W = NPLANE * NDELTA
) (
  input  logic [NDELTA*DELTA_W-1:0] deltas,
  output logic [PLANE_BUS_W-1:0]    planes
);
  import dbx_pkg::*;

  logic [NDELTA-1:0] raw [NPLANE];
  logic [NDELTA-1:0] xf  [NPLANE];

  // Transpose: bit k of delta i lands in bit i of plane k.
  always_comb begin
    for (int k = 0; k < NPLANE; k++) begin
      for (int i = 0; i < NDELTA; i++) begin
        raw[k][i] = deltas[i*DELTA_W + k];
      end
    end
  end

  // XOR chain against the next higher plane; the top plane has no neighbour.
  for (genvar k = 0; k < NPLANE; k++) begin : g_xor
    if (k == NPLANE - 1) begin : g_top
      assign xf[k] = raw[k];
    end else begin : g_mid
      assign xf[k] = raw[k] ^ raw[k+1];
    end
    assign planes[dbx_slot(k, NPLANE)*NDELTA +: NDELTA] = xf[k];
  end
endmodule

// File: rtl/dbx_transform.sv
module dbx_transform #(
  parameter int unsigned WORD_W    = dbx_pkg::DBX_WORD_W,
  parameter int unsigned NUM_WORDS = dbx_pkg::DBX_NUM_WORDS,
  localparam int unsigned DELTA_W  = WORD_W + 1,
  localparam int unsigned NDELTA   = NUM_WORDS - 1,
  localparam int unsigned CHUNK_W  = WORD_W * NUM_WORDS,
  localparam int unsigned DBUS_W   = NDELTA * DELTA_W,
  localparam int unsigned PBUS_W   = DELTA_W * NDELTA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHUNK_W-1:0] in_chunk,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_base,
  output logic [PBUS_W-1:0]  out_planes
);
  logic              s1_valid;
  logic              s2_load;
  logic              s1_take;
  logic              s2_take;
  logic [WORD_W-1:0] base_c;
  logic [DBUS_W-1:0] delta_c;
  logic [WORD_W-1:0] base_q;
  logic [DBUS_W-1:0] delta_q;
  logic [PBUS_W-1:0] planes_c;

  // Flow control: each stage moves when the stage after it is empty or draining.
  assign s2_load  = !out_valid || out_ready;
  assign in_ready = !s1_valid || s2_load;
  assign s1_take  = in_valid && in_ready;
  assign s2_take  = s1_valid && s2_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (in_ready) s1_valid  <= in_valid;
      if (s2_load)  out_valid <= s1_valid;
    end
  end

  // Stage 1: base and neighbour differences.
  dbx_delta #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_delta (
    .chunk (in_chunk),
    .base  (base_c),
    .deltas(delta_c)
  );

  dbx_stage_reg #(.W(WORD_W)) u_s1_base (
    .clk(clk), .load(s1_take), .d(base_c), .q(base_q)
  );
  dbx_stage_reg #(.W(DBUS_W)) u_s1_delta (
    .clk(clk), .load(s1_take), .d(delta_c), .q(delta_q)
  );

  // Stage 2: transpose and XOR chain.
  dbx_bitplane #(.DELTA_W(DELTA_W), .NDELTA(NDELTA)) u_plane (
    .deltas(delta_q),
    .planes(planes_c)
  );

  dbx_stage_reg #(.W(WORD_W)) u_s2_base (
    .clk(clk), .load(s2_take), .d(base_q), .q(out_base)
  );
  dbx_stage_reg #(.W(PBUS_W)) u_s2_planes (
    .clk(clk), .load(s2_take), .d(planes_c), .q(out_planes)
  );
endmodule

// File: rtl/dbx_transform_chk.sv
module dbx_transform_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PBUS_W = 1023
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_base,
  input logic [PBUS_W-1:0] out_planes
);
  logic       rst_d;
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) occ <= '0;
    else occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  // R9: a stalled result stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_base) && $stable(out_planes)));

  // R10: idle right after reset
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!out_valid && in_ready));

  // R8: input open whenever output slot is free or draining
  a_r8_flow_open: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);

  // R11: never more than two chunks inside
  a_r11_occupancy: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd2);

  // R11: no result without an accepted chunk behind it
  a_r11_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != 3'd0));
endmodule

bind dbx_transform dbx_transform_chk #(.WORD_W(WORD_W), .PBUS_W(PBUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_base  (out_base),
  .out_planes(out_planes)
);

// File: tb/dbx_transform_tb.sv
module dbx_transform_tb;
  localparam int W  = 32;
  localparam int N  = 32;
  localparam int ND = N - 1;
  localparam int DW = W + 1;
  localparam int NP = DW;
  localparam int CW = W * N;
  localparam int PW = NP * ND;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_chunk = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_base;
  logic [PW-1:0] out_planes;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [CW-1:0] src [8];

  always #4 clk = ~clk;  // 125 MHz

  dbx_transform u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_chunk(in_chunk), .out_valid(out_valid), .out_ready(out_ready),
    .out_base(out_base), .out_planes(out_planes)
  );

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_planes(input logic [CW-1:0] c);
    logic [DW-1:0] d [ND];
    logic [ND-1:0] raw [NP];
    logic [PW-1:0] r;
    for (int i = 0; i < ND; i++) begin
      longint a, b, df;
      a = $signed(c[(i+1)*W +: W]);
      b = $signed(c[i*W +: W]);
      df = a - b;
      d[i] = df[DW-1:0];
    end
    for (int k = 0; k < NP; k++)
      for (int i = 0; i < ND; i++) raw[k][i] = d[i][k];
    for (int k = 0; k < NP; k++)
      r[(NP-1-k)*ND +: ND] = (k == NP-1) ? raw[k] : (raw[k] ^ raw[k+1]);
    return r;
  endfunction

  function automatic logic [CW-1:0] inverse(input logic [W-1:0] b, input logic [PW-1:0] p);
    logic [ND-1:0] raw [NP];
    logic [CW-1:0] c;
    logic [W-1:0]  w;
    raw[NP-1] = p[0 +: ND];
    for (int k = NP-2; k >= 0; k--) raw[k] = p[(NP-1-k)*ND +: ND] ^ raw[k+1];
    w = b;
    c[0 +: W] = w;
    for (int i = 0; i < ND; i++) begin
      logic [W-1:0] dl;
      for (int k = 0; k < W; k++) dl[k] = raw[k][i];
      w = w + dl;
      c[(i+1)*W +: W] = w;
    end
    return c;
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // One chunk through an idle pipe; checks latency, base, planes, inverse.
  task automatic t_single(input logic [CW-1:0] c, input string tag);
    int cyc = 0;
    @(negedge clk);
    in_valid = 1'b1; in_chunk = c; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    #1;
    while (!out_valid && cyc < 20) begin
      @(negedge clk); #1; cyc++;
    end
    chk(cyc == 2, {tag, " R8 latency"}, CW'(cyc), CW'(2));
    chk(out_base == c[W-1:0], {tag, " R1 base"}, CW'(out_base), CW'(c[W-1:0]));
    chk(out_planes == ref_planes(c), {tag, " R2 R4 R5 R6 planes"}, CW'(out_planes), CW'(ref_planes(c)));
    chk(inverse(out_base, out_planes) == c, {tag, " R5 inverse"}, inverse(out_base, out_planes), c);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", CW'(out_valid), CW'(0));
    chk(in_ready == 1'b1, "R10 in_ready after reset", CW'(in_ready), CW'(1));
  endtask

  task automatic t_spike();
    logic [CW-1:0] c = '0;
    logic [PW-1:0] exp = '0;
    c[5*W +: W] = 32'd1;       // delta5 = +1, delta6 = -1
    exp[0 +: ND]     = 31'h20; // plane 32: sign of delta6 (bit 5)
    exp[32*ND +: ND] = 31'h10; // plane 0: bit 4 only after XOR
    t_single(c, "spike");
    chk(out_planes == exp, "R4 R6 spike bit/slot position", CW'(out_planes), CW'(exp));
  endtask

  task automatic t_constant();
    logic [CW-1:0] c;
    for (int i = 0; i < N; i++) c[i*W +: W] = 32'hDEAD_BEEF;
    t_single(c, "constant");
    chk(out_planes == '0, "R7 constant chunk all zero", CW'(out_planes), CW'(0));
  endtask

  task automatic t_extremes();
    logic [CW-1:0] c;
    logic [PW-1:0] exp = '0;
    for (int i = 0; i < N; i++) c[i*W +: W] = (i % 2 == 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    // deltas alternate +0x0FFFFFFFF (odd i) and -0x0FFFFFFFF = 0x1_00000001 (even i)
    // raw plane 32 bits on even i (bit positions 1,3,..); plane0 all ones; planes 1..31 odd-i positions
    // transformed: plane32 = even mask, planes 1..30 zero, plane31 = all ones, plane0 = even mask
    exp[0 +: ND]     = 31'h2AAA_AAAA;
    exp[1*ND +: ND]  = 31'h7FFF_FFFF;
    exp[32*ND +: ND] = 31'h2AAA_AAAA;
    t_single(c, "extremes");
    chk(out_planes == exp, "R3 no overflow at extremes", CW'(out_planes), CW'(exp));
  endtask

  task automatic fill_src(input bit smooth);
    for (int j = 0; j < 8; j++) begin
      logic [W-1:0] w;
      seed = lcg(seed);
      w = seed;
      for (int i = 0; i < N; i++) begin
        seed = lcg(seed);
        if (smooth) w = w + W'(int'(seed[18:16]) - 3);
        else w = seed;
        src[j][i*W +: W] = w;
      end
    end
  endtask

  // mode 0: always ready; 1: alternate; 2: stalled for first 8 cycles
  task automatic t_stream(input int n, input int mode, input string tag);
    int sent = 0, rcv = 0, first = -1, last = -1;
    bit prev_stall = 1'b0;
    logic [PW-1:0] prev_p = '0;
    logic [W-1:0]  prev_b = '0;
    for (int cyc = 0; cyc < 300 && rcv < n; cyc++) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc >= 8);
      in_valid  = (sent < n);
      if (sent < n) in_chunk = src[sent];
      #1;
      if (prev_stall)
        chk(out_valid && out_planes == prev_p && out_base == prev_b, {tag, " R9 held while stalled"},
            CW'(out_planes), CW'(prev_p));
      if (mode == 2 && cyc == 7) begin
        chk(sent == 2, {tag, " R11 two chunks inside"}, CW'(sent), CW'(2));
        chk(in_ready == 1'b0, {tag, " R11 in_ready low when full"}, CW'(in_ready), CW'(0));
      end
      if (out_valid && out_ready) begin
        chk(out_planes == ref_planes(src[rcv]) && out_base == src[rcv][W-1:0],
            {tag, " R11 order and content"}, CW'(out_planes), CW'(ref_planes(src[rcv])));
        if (first < 0) first = cyc;
        last = cyc;
        rcv++;
      end
      prev_stall = out_valid && !out_ready;
      prev_p = out_planes;
      prev_b = out_base;
      if (in_valid && in_ready) sent++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    chk(rcv == n, {tag, " R11 all delivered"}, CW'(rcv), CW'(n));
    if (mode == 0)
      chk(last - first == n - 1, {tag, " R8 one per cycle"}, CW'(last - first), CW'(n - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_spike();
    t_constant();
    t_extremes();
    fill_src(1'b1);
    t_single(src[0], "smooth");
    t_stream(6, 0, "stream");
    fill_src(1'b0);
    t_single(src[1], "random");
    t_stream(5, 1, "alternate");
    fill_src(1'b1);
    t_stream(6, 2, "stall");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule